// File: doc/BRIEF.md
# USB Endpoint-0 Status and Interrupt Controller

This block holds the status and control state for the default control endpoint of a low-speed USB device function. The packet engine sends it single-cycle strobes when a packet leaves on endpoint 0 and when one arrives. Each strobe sets a sticky flag. Software clears a flag by writing 1 to its own bit in a write-only clear register. Two per-flag enable bits combine the flags into one level-sensitive interrupt line. When an OUT data phase starts, the block latches a handshake decision. The answer is ACK only if software has armed reception and no earlier received packet is still waiting.

The block watches the D+ and D- lines through a parameterised synchroniser. It treats an SE0 state held for `RST_CYCLES` consecutive samples as a bus reset. A bus reset drives an internal reset output, clears all endpoint state in this block and sets a sticky bus-reset flag. Only power-on reset or an explicit software clear removes that flag. A software suspend bit stops the module clock enable and raises a power-down request for the analog front end.

Registers, at word addresses: 0 = status (read-only), 1 = control (read/write), 2 = flag clear (write-only, reads 0), 3 = unused (reads 0). Read data is a combinational function of the address.

Top module: `ep0_status_ctl`

## Requirements
- R1: After power-on reset, the status and control registers read 0, `hs_ack_o`, `irq_o`, `usb_rst_o` and `analog_pd_o` are 0, and `clk_en_o` is 1.
- R2: A one-cycle `tx_done_i` sets status bit 0 from the next cycle on. A one-cycle `rx_done_i` sets status bit 1 and clears control bit 2 (receive enable) from the next cycle on.
- R3: Writes to the status address, and 0 bits written to the clear address (address 2), leave the flags unchanged. A 1 in clear bit 0, 1 or 2 clears status bit 0, 1 or 2 on the next cycle. Clearing a flag that is already 0 leaves it 0. Address 2 reads as 0.
- R4: If a set strobe and a clear write for the same flag fall in the same cycle, the flag is 1 afterwards. If a receive strobe and a control write fall in the same cycle, the receive enable is 0 afterwards.
- R5: `irq_o` is 1 exactly when (status bit 0 and control bit 0) or (status bit 1 and control bit 1), and it follows the register state with no added delay.
- R6: On a cycle with `out_start_i` high, `hs_ack_o` takes the value (control bit 2 AND NOT status bit 1) from the next cycle on. It holds that value until the next `out_start_i`.
- R7: SE0 (`dp_i` = `dm_i` = 0) is seen through `LINE_SYNC` register stages. Once `RST_CYCLES` consecutive synchronised SE0 samples have been seen, `usb_rst_o` is 1. It stays 1 while SE0 persists and falls `LINE_SYNC`+1 cycles after the lines leave SE0. Shorter SE0 runs change nothing.
- R8: While `usb_rst_o` is 1, status bits 0 and 1, all control bits and `hs_ack_o` are cleared, and status bit 2 is set. Status bit 2 then stays 1 until a clear-bit-2 write or power-on reset.
- R9: Control bit 3 (suspend) drives `analog_pd_o` = 1 and `clk_en_o` = 0. Both outputs change at the clock edge that updates the bit.
- R10: Control bits 0 to 3 read back as written. Register bits above the defined fields read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running block clock |
| por_n_i | input | 1 | Asynchronous power-on reset, active low |
| cpu_sel_i | input | 1 | Register access select |
| cpu_wr_i | input | 1 | Write strobe, qualified by select |
| cpu_addr_i | input | ADDR_W | Register word address |
| cpu_wdata_i | input | DATA_W | Write data |
| cpu_rdata_o | output | DATA_W | Read data for the addressed register |
| tx_done_i | input | 1 | Packet sent on endpoint 0 (one-cycle strobe) |
| rx_done_i | input | 1 | Packet received on endpoint 0 (one-cycle strobe) |
| out_start_i | input | 1 | Start of an OUT data phase |
| dp_i | input | 1 | D+ line level |
| dm_i | input | 1 | D- line level |
| hs_ack_o | output | 1 | Handshake decision: 1 = ACK, 0 = NAK |
| irq_o | output | 1 | Level interrupt request |
| usb_rst_o | output | 1 | Internal reset request from bus-reset detection |
| clk_en_o | output | 1 | Module clock enable, low while suspended |
| analog_pd_o | output | 1 | Power-down request for nonessential analog circuitry |

## Verification
The hardest case to reach from the ports is a clash of two writers on the same register bit in one cycle. One form is a completion strobe arriving on the cycle of a clear write. Another is a bus reset becoming active while software writes control bits. Directed steps place the strobe and the register write on the same clock edge. A long randomised phase then fires strobes, writes and SE0 bursts of lengths just below and just above the threshold at independent rates, and a behavioural model checks every cycle. The directed SE0 runs are `RST_CYCLES`-1 and `RST_CYCLES`+4 samples long, so they show both that a near-threshold glitch is ignored and that the bus-reset flag survives the reset it causes.

// File: rtl/ep0_stat_pkg.sv
package ep0_stat_pkg;

   // register word addresses
   localparam int unsigned REG_STAT = 0;
   localparam int unsigned REG_CTRL = 1;
   localparam int unsigned REG_CLR  = 2;

   // flag positions in the status and clear registers
   localparam int unsigned NUM_FLAGS = 3;
   localparam int unsigned F_TX      = 0;
   localparam int unsigned F_RX      = 1;
   localparam int unsigned F_BRST    = 2;

   // flags wiped by the bus-reset internal reset (bus-reset flag survives)
   localparam logic [NUM_FLAGS-1:0] SOFT_MASK = 3'b011;

   // control register, bit 0 in the last field
   typedef struct packed {
      logic susp;
      logic rx_en;
      logic rx_ie;
      logic tx_ie;
   } ctrl_t;

   localparam int unsigned CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/ep0_flag_bit.sv
module ep0_flag_bit (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic soft_rst_i,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);

   logic flag_q;

   // priority: soft reset, then set event, then software clear
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         flag_q <= 1'b0;
      else if (soft_rst_i) flag_q <= 1'b0;
      else if (set_i)      flag_q <= 1'b1;
      else if (clr_i)      flag_q <= 1'b0;
   end

   assign flag_o = flag_q;

endmodule

// File: rtl/ep0_bus_rst_det.sv
module ep0_bus_rst_det #(
   parameter int unsigned LINE_SYNC  = 2,
   parameter int unsigned RST_CYCLES = 16
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic dp_i,
   input  logic dm_i,
   output logic rst_active_o
);

   localparam int unsigned CNT_W = $clog2(RST_CYCLES + 1);

   logic se0_raw;
   logic se0_s;
   logic [CNT_W-1:0] cnt_q;

   assign se0_raw = ~dp_i & ~dm_i;

   generate
      if (LINE_SYNC == 0) begin : g_nosync
         assign se0_s = se0_raw;
      end else begin : g_sync
         logic [LINE_SYNC-1:0] sq;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               sq <= '0;
            end else begin
               sq[0] <= se0_raw;
               for (int i = 1; i < int'(LINE_SYNC); i++) sq[i] <= sq[i-1];
            end
         end
         assign se0_s = sq[LINE_SYNC-1];
      end
   endgenerate

   // saturating run-length counter of synchronised SE0 samples
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              cnt_q <= '0;
      else if (!se0_s)                          cnt_q <= '0;
      else if (cnt_q != CNT_W'(RST_CYCLES))     cnt_q <= cnt_q + 1'b1;
   end

   assign rst_active_o = (cnt_q == CNT_W'(RST_CYCLES));

endmodule

// File: rtl/ep0_csr.sv
module ep0_csr
   import ep0_stat_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 2
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 soft_rst_i,
   input  logic                 sel_i,
   input  logic                 wr_i,
   input  logic [ADDR_W-1:0]    addr_i,
   input  logic [DATA_W-1:0]    wdata_i,
   input  logic                 rx_done_i,
   input  logic [NUM_FLAGS-1:0] flags_i,
   output ctrl_t                ctrl_o,
   output logic [NUM_FLAGS-1:0] clr_o,
   output logic [DATA_W-1:0]    rdata_o
);

   logic  wr_ctrl;
   logic  wr_clr;
   ctrl_t ctrl_q;
   logic  unused_wdata;

   assign wr_ctrl = sel_i & wr_i & (addr_i == ADDR_W'(REG_CTRL));
   assign wr_clr  = sel_i & wr_i & (addr_i == ADDR_W'(REG_CLR));

   // write-only clear strobes: a 0 bit requests nothing
   assign clr_o = wr_clr ? wdata_i[NUM_FLAGS-1:0] : '0;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ctrl_q <= '0;
      end else if (soft_rst_i) begin
         ctrl_q <= '0;
      end else begin
         if (wr_ctrl) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
         // receive strobe disarms reception; it wins over a same-cycle write
         if (rx_done_i) ctrl_q.rx_en <= 1'b0;
      end
   end

   always_comb begin
      rdata_o = '0;
      case (addr_i)
         ADDR_W'(REG_STAT): rdata_o[NUM_FLAGS-1:0] = flags_i;
         ADDR_W'(REG_CTRL): rdata_o[CTRL_W-1:0]    = ctrl_q;
         default:           rdata_o                = '0;
      endcase
   end

   assign ctrl_o       = ctrl_q;
   assign unused_wdata = ^wdata_i[DATA_W-1:CTRL_W];

endmodule

// File: rtl/ep0_status_ctl.sv
module ep0_status_ctl
   import ep0_stat_pkg::*;
#(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned ADDR_W     = 2,
   parameter int unsigned RST_CYCLES = 16,
   parameter int unsigned LINE_SYNC  = 2
) (
   input  logic              clk_i,
   input  logic              por_n_i,
   input  logic              cpu_sel_i,
   input  logic              cpu_wr_i,
   input  logic [ADDR_W-1:0] cpu_addr_i,
   input  logic [DATA_W-1:0] cpu_wdata_i,
   output logic [DATA_W-1:0] cpu_rdata_o,
   input  logic              tx_done_i,
   input  logic              rx_done_i,
   input  logic              out_start_i,
   input  logic              dp_i,
   input  logic              dm_i,
   output logic              hs_ack_o,
   output logic              irq_o,
   output logic              usb_rst_o,
   output logic              clk_en_o,
   output logic              analog_pd_o
);

   // elaboration-time parameter checks
   generate
      if (RST_CYCLES < 1) begin : g_bad_rst
         $error("RST_CYCLES must be at least 1");
      end
      if (DATA_W < 8) begin : g_bad_data
         $error("DATA_W must be at least 8");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("ADDR_W must be at least 2");
      end
      if (LINE_SYNC > 4) begin : g_bad_sync
         $error("LINE_SYNC must not exceed 4");
      end
   endgenerate

   logic                 rst_active;
   logic [NUM_FLAGS-1:0] set_v;
   logic [NUM_FLAGS-1:0] clr_v;
   logic [NUM_FLAGS-1:0] flag_q;
   ctrl_t                ctrl_q;
   logic                 hs_q;

   ep0_bus_rst_det #(
      .LINE_SYNC (LINE_SYNC),
      .RST_CYCLES(RST_CYCLES)
   ) u_brst (
      .clk_i       (clk_i),
      .rst_ni      (por_n_i),
      .dp_i        (dp_i),
      .dm_i        (dm_i),
      .rst_active_o(rst_active)
   );

   ep0_csr #(
      .DATA_W(DATA_W),
      .ADDR_W(ADDR_W)
   ) u_csr (
      .clk_i     (clk_i),
      .rst_ni    (por_n_i),
      .soft_rst_i(rst_active),
      .sel_i     (cpu_sel_i),
      .wr_i      (cpu_wr_i),
      .addr_i    (cpu_addr_i),
      .wdata_i   (cpu_wdata_i),
      .rx_done_i (rx_done_i),
      .flags_i   (flag_q),
      .ctrl_o    (ctrl_q),
      .clr_o     (clr_v),
      .rdata_o   (cpu_rdata_o)
   );

   assign set_v[F_TX]   = tx_done_i;
   assign set_v[F_RX]   = rx_done_i;
   assign set_v[F_BRST] = rst_active;

   generate
      for (genvar i = 0; i < int'(NUM_FLAGS); i++) begin : g_flag
         ep0_flag_bit u_flag (
            .clk_i     (clk_i),
            .rst_ni    (por_n_i),
            .soft_rst_i(rst_active & SOFT_MASK[i]),
            .set_i     (set_v[i]),
            .clr_i     (clr_v[i]),
            .flag_o    (flag_q[i])
         );
      end
   endgenerate

   // handshake decision latched at the start of each OUT data phase
   always_ff @(posedge clk_i or negedge por_n_i) begin
      if (!por_n_i)         hs_q <= 1'b0;
      else if (rst_active)  hs_q <= 1'b0;
      else if (out_start_i) hs_q <= ctrl_q.rx_en & ~flag_q[F_RX];
   end

   assign hs_ack_o    = hs_q;
   assign irq_o       = (flag_q[F_TX] & ctrl_q.tx_ie) | (flag_q[F_RX] & ctrl_q.rx_ie);
   assign usb_rst_o   = rst_active;
   assign clk_en_o    = ~ctrl_q.susp;
   assign analog_pd_o = ctrl_q.susp;

endmodule

// File: rtl/ep0_status_ctl_chk.sv
module ep0_status_ctl_chk
   import ep0_stat_pkg::*;
#(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned ADDR_W    = 2,
   parameter int unsigned LINE_SYNC = 2
) (
   input logic                 clk_i,
   input logic                 por_n_i,
   input logic                 cpu_sel_i,
   input logic                 cpu_wr_i,
   input logic [ADDR_W-1:0]    cpu_addr_i,
   input logic [DATA_W-1:0]    cpu_wdata_i,
   input logic                 tx_done_i,
   input logic                 rx_done_i,
   input logic                 out_start_i,
   input logic                 dp_i,
   input logic                 dm_i,
   input logic                 hs_ack_o,
   input logic                 irq_o,
   input logic                 usb_rst_o,
   input logic                 analog_pd_o,
   input logic [NUM_FLAGS-1:0] flag_q,
   input ctrl_t                ctrl_q
);

   logic wr_clr;
   logic wr_ctrl;

   assign wr_clr  = cpu_sel_i && cpu_wr_i && (cpu_addr_i == ADDR_W'(REG_CLR));
   assign wr_ctrl = cpu_sel_i && cpu_wr_i && (cpu_addr_i == ADDR_W'(REG_CTRL));

   assert_tx_set_wins_R4: assert property (@(posedge clk_i) disable iff (!por_n_i)
      (tx_done_i && !usb_rst_o) |=> flag_q[F_TX]);

   assert_rx_set_disarm_R2: assert property (@(posedge clk_i) disable iff (!por_n_i)
      (rx_done_i && !usb_rst_o) |=> (flag_q[F_RX] && !ctrl_q.rx_en));

   assert_tx_clear_R3: assert property (@(posedge clk_i) disable iff (!por_n_i)
      (wr_clr && cpu_wdata_i[F_TX] && !tx_done_i) |=> !flag_q[F_TX]);

   assert_irq_quiet_R5: assert property (@(posedge clk_i) disable iff (!por_n_i)
      (!flag_q[F_TX] && !flag_q[F_RX]) |-> !irq_o);

   assert_hs_hold_R6: assert property (@(posedge clk_i) disable iff (!por_n_i)
      (!out_start_i && !usb_rst_o) |=> $stable(hs_ack_o));

   assert_hs_ack_cause_R6: assert property (@(posedge clk_i) disable iff (!por_n_i)
      $rose(hs_ack_o) |-> $past(ctrl_q.rx_en && !flag_q[F_RX]));

   assert_brst_line_R7: assert property (@(posedge clk_i) disable iff (!por_n_i)
      $rose(usb_rst_o) |-> $past(!dp_i && !dm_i, LINE_SYNC + 1));

   assert_brst_sticky_R8: assert property (@(posedge clk_i) disable iff (!por_n_i)
      (flag_q[F_BRST] && !(wr_clr && cpu_wdata_i[F_BRST])) |=> flag_q[F_BRST]);

   assert_brst_wipe_R8: assert property (@(posedge clk_i) disable iff (!por_n_i)
      usb_rst_o |=> (flag_q[F_BRST] && !analog_pd_o && !irq_o && !hs_ack_o));

   assert_pd_cause_R9: assert property (@(posedge clk_i) disable iff (!por_n_i)
      !$stable(analog_pd_o) |-> $past(wr_ctrl || usb_rst_o));

endmodule

bind ep0_status_ctl ep0_status_ctl_chk #(
   .DATA_W   (DATA_W),
   .ADDR_W   (ADDR_W),
   .LINE_SYNC(LINE_SYNC)
) u_chk (
   .clk_i      (clk_i),
   .por_n_i    (por_n_i),
   .cpu_sel_i  (cpu_sel_i),
   .cpu_wr_i   (cpu_wr_i),
   .cpu_addr_i (cpu_addr_i),
   .cpu_wdata_i(cpu_wdata_i),
   .tx_done_i  (tx_done_i),
   .rx_done_i  (rx_done_i),
   .out_start_i(out_start_i),
   .dp_i       (dp_i),
   .dm_i       (dm_i),
   .hs_ack_o   (hs_ack_o),
   .irq_o      (irq_o),
   .usb_rst_o  (usb_rst_o),
   .analog_pd_o(analog_pd_o),
   .flag_q     (flag_q),
   .ctrl_q     (ctrl_q)
);

// File: tb/ep0_status_ctl_tb.sv
module ep0_status_ctl_tb;

   localparam int CLK_PERIOD = 10;
   localparam int RSTC       = 6;
   localparam int SYNC       = 2;

   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic       sel = 1'b0, wr = 1'b0;
   logic [1:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       tx_done = 1'b0, rx_done = 1'b0, out_start = 1'b0;
   logic       dp = 1'b1, dm = 1'b0;
   logic       hs_ack, irq, usb_rst, clk_en, apd;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ep0_status_ctl #(.DATA_W(8), .ADDR_W(2), .RST_CYCLES(RSTC), .LINE_SYNC(SYNC)) u_dut (
      .clk_i(clk), .por_n_i(por_n), .cpu_sel_i(sel), .cpu_wr_i(wr), .cpu_addr_i(addr),
      .cpu_wdata_i(wdata), .cpu_rdata_o(rdata), .tx_done_i(tx_done), .rx_done_i(rx_done),
      .out_start_i(out_start), .dp_i(dp), .dm_i(dm), .hs_ack_o(hs_ack), .irq_o(irq),
      .usb_rst_o(usb_rst), .clk_en_o(clk_en), .analog_pd_o(apd));

   // ---------------- behavioural reference model ----------------
   bit m_tx, m_rx, m_brst, m_txie, m_rxie, m_rxen, m_susp, m_hs;
   bit m_sq [0:7];
   int m_run;

   always @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         {m_tx, m_rx, m_brst, m_txie, m_rxie, m_rxen, m_susp, m_hs} = '0;
         for (int i = 0; i < 8; i++) m_sq[i] = 1'b0;
         m_run = 0;
      end else begin
         bit raw, s_now, active, wctl, wclr;
         raw    = !dp && !dm;
         s_now  = (SYNC == 0) ? raw : m_sq[SYNC-1];
         for (int i = SYNC - 1; i > 0; i--) m_sq[i] = m_sq[i-1];
         m_sq[0] = raw;
         active = (m_run == RSTC);
         wctl   = sel && wr && addr == 2'd1;
         wclr   = sel && wr && addr == 2'd2;
         if (active) begin
            {m_tx, m_rx, m_txie, m_rxie, m_rxen, m_susp, m_hs} = '0;
         end else begin
            bit old_rxen, old_rx;
            old_rxen = m_rxen;
            old_rx   = m_rx;
            if (tx_done) m_tx = 1; else if (wclr && wdata[0]) m_tx = 0;
            if (rx_done) m_rx = 1; else if (wclr && wdata[1]) m_rx = 0;
            if (wctl) begin
               m_txie = wdata[0]; m_rxie = wdata[1]; m_rxen = wdata[2]; m_susp = wdata[3];
            end
            if (rx_done) m_rxen = 0;
            if (out_start) m_hs = old_rxen && !old_rx;
         end
         if (active) m_brst = 1; else if (wclr && wdata[2]) m_brst = 0;
         if (!s_now) m_run = 0; else if (m_run < RSTC) m_run++;
      end
   end

   function automatic logic [7:0] m_rdata(input logic [1:0] a);
      case (a)
         2'd0:    return {5'b0, m_brst, m_rx, m_tx};
         2'd1:    return {4'b0, m_susp, m_rxen, m_rxie, m_txie};
         default: return 8'h00;
      endcase
   endfunction

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // compare against the model every clock, away from both edges
   always @(posedge clk) begin
      #(CLK_PERIOD/4);
      if (por_n && !done) begin
         chk(irq, m_tx & m_txie | m_rx & m_rxie, "R5 irq vs model");
         chk(hs_ack, m_hs, "R6 hs_ack vs model");
         chk(usb_rst, m_run == RSTC, "R7 usb_rst vs model");
         chk(clk_en, !m_susp, "R9 clk_en vs model");
         chk(apd, m_susp, "R9 analog_pd vs model");
         chk(rdata, m_rdata(addr), "R10 rdata vs model");
      end
   end

   // ---------------- drivers ----------------
   task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
      @(negedge clk); sel = 0; wr = 0;
   endtask

   task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string tag);
      @(negedge clk); sel = 1; wr = 0; addr = a;
      @(posedge clk); #(CLK_PERIOD/4);
      chk(rdata, exp, tag);
   endtask

   task automatic pulse(input int which);
      @(negedge clk);
      case (which)
         0: tx_done = 1;
         1: rx_done = 1;
         default: out_start = 1;
      endcase
      @(negedge clk); tx_done = 0; rx_done = 0; out_start = 0;
   endtask

   task automatic se0_run(input int n, output bit seen);
      seen = 0;
      @(negedge clk); dp = 0; dm = 0;
      for (int i = 0; i < n + SYNC + 3; i++) begin
         @(negedge clk);
         if (i == n - 1) begin dp = 1; dm = 0; end
         if (usb_rst) seen = 1;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         bad++;
         $display("FAIL watchdog R1 actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      bit seen;
      repeat (3) @(negedge clk);
      por_n = 1;
      // R1 reset state
      chk(hs_ack, 0, "R1 hs_ack");
      chk(irq, 0, "R1 irq");
      chk(usb_rst, 0, "R1 usb_rst");
      chk(clk_en, 1, "R1 clk_en");
      chk(apd, 0, "R1 analog_pd");
      rd_chk(0, 8'h00, "R1 status");
      rd_chk(1, 8'h00, "R1 control");
      // R2 transmit flag, R5 gating
      pulse(0);
      rd_chk(0, 8'h01, "R2 tx flag set");
      chk(irq, 0, "R5 irq masked");
      wr_reg(1, 8'h01);
      chk(irq, 1, "R5 irq enabled");
      // R3 ignored writes and clears
      wr_reg(0, 8'h00);
      wr_reg(0, 8'hFF);
      wr_reg(2, 8'h00);
      rd_chk(0, 8'h01, "R3 status/zero writes ignored");
      rd_chk(2, 8'h00, "R3 clear reg reads 0");
      wr_reg(2, 8'h01);
      rd_chk(0, 8'h00, "R3 tx flag cleared");
      chk(irq, 0, "R5 irq after clear");
      wr_reg(2, 8'h01);
      rd_chk(0, 8'h00, "R3 clear of clear flag");
      // R10 readback of upper bits
      wr_reg(1, 8'hF6);
      rd_chk(1, 8'h06, "R10 ctrl readback");
      // R6 handshake
      pulse(2);
      chk(hs_ack, 1, "R6 ack when armed");
      pulse(1);
      rd_chk(0, 8'h02, "R2 rx flag set");
      rd_chk(1, 8'h02, "R2 rx_en cleared");
      chk(irq, 1, "R5 rx irq");
      chk(hs_ack, 1, "R6 hold between phases");
      pulse(2);
      chk(hs_ack, 0, "R6 nak with pending rx");
      wr_reg(2, 8'h02);
      pulse(2);
      chk(hs_ack, 0, "R6 nak without rx_en");
      wr_reg(1, 8'h06);
      pulse(2);
      chk(hs_ack, 1, "R6 ack re-armed");
      // R4 set wins over clear in the same cycle
      @(negedge clk); tx_done = 1; sel = 1; wr = 1; addr = 2'd2; wdata = 8'h01;
      @(negedge clk); tx_done = 0; sel = 0; wr = 0;
      rd_chk(0, 8'h01, "R4 set beats clear");
      @(negedge clk); rx_done = 1; sel = 1; wr = 1; addr = 2'd1; wdata = 8'h06;
      @(negedge clk); rx_done = 0; sel = 0; wr = 0;
      rd_chk(1, 8'h02, "R4 rx strobe beats rx_en write");
      wr_reg(2, 8'h03);
      wr_reg(1, 8'h06);
      // R9 suspend
      wr_reg(1, 8'h0E);
      chk(clk_en, 0, "R9 clock stopped");
      chk(apd, 1, "R9 power-down");
      wr_reg(1, 8'h06);
      chk(clk_en, 1, "R9 clock resumed");
      // R7 short SE0 ignored
      se0_run(RSTC - 1, seen);
      chk(seen, 0, "R7 short SE0 ignored");
      rd_chk(0, 8'h00, "R7 no reset flag");
      rd_chk(1, 8'h06, "R7 control kept");
      // R7/R8 long SE0
      wr_reg(1, 8'h0F);
      pulse(0);
      se0_run(RSTC + 4, seen);
      chk(seen, 1, "R7 long SE0 detected");
      chk(usb_rst, 0, "R7 released");
      rd_chk(0, 8'h04, "R8 reset flag only");
      rd_chk(1, 8'h00, "R8 control wiped");
      chk(hs_ack, 0, "R8 hs wiped");
      wr_reg(2, 8'h03);
      rd_chk(0, 8'h04, "R8 flag sticky");
      wr_reg(2, 8'h04);
      rd_chk(0, 8'h00, "R8 flag cleared");
      // randomised phase
      for (int c = 0; c < 4000; c++) begin
         @(negedge clk);
         tx_done   = ($urandom_range(7) == 0);
         rx_done   = ($urandom_range(7) == 0);
         out_start = ($urandom_range(5) == 0);
         sel = 1; wr = ($urandom_range(3) == 0);
         addr = 2'($urandom_range(3)); wdata = 8'($urandom);
         if ($urandom_range(60) == 0) begin dp = 0; dm = 0; end
         else if (!dp && !dm && $urandom_range(RSTC + 2) == 0) begin dp = 1; dm = 0; end
         else if (dp && $urandom_range(40) == 0) begin dp = 0; dm = 1; end
         else if (!dp && dm) begin dp = 1; dm = 0; end
      end
      @(negedge clk); tx_done = 0; rx_done = 0; out_start = 0; sel = 0; wr = 0; dp = 1; dm = 0;
      // R8 power-on reset clears the bus-reset flag
      se0_run(RSTC + 2, seen);
      rd_chk(0, 8'h04, "R8 flag before POR");
      @(negedge clk); por_n = 0;
      repeat (2) @(negedge clk);
      por_n = 1;
      rd_chk(0, 8'h00, "R8 POR clears flag");
      chk(clk_en, 1, "R1 clk_en after POR");
      repeat (3) @(negedge clk);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule